// File: doc/BRIEF.md
# Dual-Select Static Word Memory

This block is a 256-word by 4-bit storage array with a data input port and a separate data output port. Two chip selects of opposite polarity must both be asserted before the array does anything: the first is active low and the second is active high. An active-low write enable picks a write, and an active-low output enable lets a read drive the outputs.

The output appears as a 4-bit data bus plus one drive-enable bit. A surrounding design, or the testbench here, turns the pair into a three-state bus. A write is committed on the rising clock edge while the write condition holds. Reads are combinational from the addressed word. Because of this, the word just written is on the outputs as soon as write enable is released, and no stale value is shown first. The array contents have no reset.

Top module: `dsram_top`

## Requirements
- R1: The block is selected only when `selLowN` is 0 and `selHigh` is 1. In every other combination `outDrive` is 0, whatever `wrEnN` and `outEnN` are.
- R2: While the block is not selected, a rising clock edge with `wrEnN` at 0 changes no stored word.
- R3: When the block is selected and `wrEnN` is 0 at a rising clock edge, `dataIn` is stored at `addr`. A read of that address in the next cycle returns it.
- R4: While the block is selected and `wrEnN` is 0, `outDrive` is 0 for either value of `outEnN`.
- R5: When the block is selected, `wrEnN` is 1 and `outEnN` is 0, `outDrive` is 1 and `dataOut` equals the word stored at `addr`, not inverted.
- R6: When the block is selected, `wrEnN` is 1 and `outEnN` is 1, `outDrive` is 0.
- R7: Whenever `outDrive` is 0, `dataOut` is all zeros.
- R8: When `wrEnN` rises after a write edge and a read of the same address follows, `dataOut` carries the new word within the first read cycle.
- R9: A write to one address leaves the words at all other addresses unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its rising edge |
| selLowN | input | 1 | Active-low chip select |
| selHigh | input | 1 | Active-high chip select |
| wrEnN | input | 1 | Active-low write enable |
| outEnN | input | 1 | Active-low output enable |
| addr | input | 8 | Word address |
| dataIn | input | 4 | Write data |
| dataOut | output | 4 | Read data; zero when not driven |
| outDrive | output | 1 | Output drive enable for the three-state bus |

## Verification
The bench first fills all 256 words with an address-derived pattern and reads them back. This separates correct addressing and non-inverted data from aliasing or bit flips. It then applies write strobes under each of the three deselected select combinations. A later read shows whether a deselected write leaked into the array. Writes are issued with output enable both low and high, followed directly by a read of the same address, which tells a float during the whole write apart from early drive or a stale first read. Alternating writes to neighbouring addresses show that words are independent.

// File: rtl/dsram_pkg.sv
package dsram_pkg;
  // Strobes from the mode decoder to the storage datapath
  typedef struct packed {
    logic selected;
    logic wrStrobe;
    logic rdDrive;
  } dsramStrobes_t;
endpackage

// File: rtl/dsram_ctrl.sv
module dsram_ctrl
  import dsram_pkg::*;
(
  input  logic          selLowN,
  input  logic          selHigh,
  input  logic          wrEnN,
  input  logic          outEnN,
  output dsramStrobes_t strobes
);
  logic chipOn;

  always_comb begin
    chipOn           = !selLowN && selHigh;
    strobes.selected = chipOn;
    // a write overrides output enable and floats the outputs
    strobes.wrStrobe = chipOn && !wrEnN;
    strobes.rdDrive  = chipOn && wrEnN && !outEnN;
  end
endmodule

// File: rtl/dsram_datapath.sv
module dsram_datapath
  import dsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  dsramStrobes_t     strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [DATA_W-1:0] rdWord;

  // one write port; contents are deliberately not reset
  always_ff @(posedge clk) begin
    if (strobes.wrStrobe) memArr[addr] <= dataIn;
  end

  // combinational read: a freshly written word is visible once the edge passes
  always_comb begin
    rdWord  = memArr[addr];
    dataOut = strobes.rdDrive ? rdWord : '0;
  end
endmodule

// File: rtl/dsram_top.sv
module dsram_top
  import dsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              selLowN,
  input  logic              selHigh,
  input  logic              wrEnN,
  input  logic              outEnN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              outDrive
);
  dsramStrobes_t strobes;

  dsram_ctrl u_ctrl (
    .selLowN (selLowN),
    .selHigh (selHigh),
    .wrEnN   (wrEnN),
    .outEnN  (outEnN),
    .strobes (strobes)
  );

  dsram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .strobes (strobes),
    .addr    (addr),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

  assign outDrive = strobes.rdDrive;
endmodule

// File: rtl/dsram_chk.sv
module dsram_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              selLowN,
  input logic              selHigh,
  input logic              wrEnN,
  input logic              outEnN,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dataIn,
  input logic [DATA_W-1:0] dataOut,
  input logic              outDrive
);
  // no reset on this block: properties wait until one edge has passed
  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  a_r1_standby_float: assert property (@(posedge clk) disable iff (!primed)
    !(!selLowN && selHigh) |-> !outDrive);

  a_r4_write_float: assert property (@(posedge clk) disable iff (!primed)
    (!selLowN && selHigh && !wrEnN) |-> !outDrive);

  a_r6_oe_off_float: assert property (@(posedge clk) disable iff (!primed)
    (!selLowN && selHigh && wrEnN && outEnN) |-> !outDrive);

  a_r7_zero_when_idle: assert property (@(posedge clk) disable iff (!primed)
    !outDrive |-> (dataOut == '0));

  // R3 and R8: a read right after a write to the same address returns the new word
  a_r3_write_then_read: assert property (@(posedge clk) disable iff (!primed)
    ($past(!selLowN && selHigh && !wrEnN) && !selLowN && selHigh && wrEnN && !outEnN
     && addr == $past(addr)) |-> (outDrive && dataOut == $past(dataIn)));
endmodule

bind dsram_top dsram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dsram_top_bench.sv
module dsram_top_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       selLowN = 1'b1;
  logic       selHigh = 1'b0;
  logic       wrEnN = 1'b1;
  logic       outEnN = 1'b1;
  logic [7:0] addr = '0;
  logic [3:0] dataIn = '0;
  logic [3:0] dataOut;
  logic       outDrive;
  wire  [3:0] busLine;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;
  int model [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  dsram_top u_dsram_top (
    .clk(clk), .selLowN(selLowN), .selHigh(selHigh), .wrEnN(wrEnN),
    .outEnN(outEnN), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .outDrive(outDrive)
  );

  // modelled three-state bus
  assign busLine = outDrive ? dataOut : 4'bz;

  // drive one cycle, compare against the behavioural model, then update it
  task automatic step(input string req, input logic sl, input logic sh,
                      input logic we, input logic oe, input int a, input int d);
    bit sel;
    bit expDrive;
    int expData;
    @(negedge clk);
    selLowN = sl; selHigh = sh; wrEnN = we; outEnN = oe;
    addr = 8'(a); dataIn = 4'(d);
    #1;
    sel      = (sl == 1'b0) && (sh == 1'b1);
    expDrive = sel && we && !oe;
    expData  = expDrive ? model[a] : 0;
    testsRun++;
    if (outDrive !== expDrive) begin
      testsFailed++;
      $display("FAIL %s drive: actual %0b expected %0b (addr %0d)", req, outDrive, expDrive, a);
    end
    testsRun++;
    if (int'(dataOut) != expData || (expDrive && int'(busLine) != expData)) begin
      testsFailed++;
      $display("FAIL %s data: actual %0h expected %0h (addr %0d)", req, dataOut, expData, a);
    end
    if (sel && !we) model[a] = d;
  endtask

  initial begin
    // R3 R5 R9: fill every word, then read each back
    for (int i = 0; i < 256; i++) step("R3", 1'b0, 1'b1, 1'b0, 1'b0, i, (i*7+3) & 15);
    for (int i = 0; i < 256; i++) step("R5", 1'b0, 1'b1, 1'b1, 1'b0, i, 0);
    // R1 R2: write strobes while deselected in all three ways
    step("R2", 1'b1, 1'b1, 1'b0, 1'b0, 10, 4'hF);
    step("R2", 1'b0, 1'b0, 1'b0, 1'b0, 11, 4'hF);
    step("R2", 1'b1, 1'b0, 1'b0, 1'b0, 12, 4'hF);
    step("R1", 1'b1, 1'b1, 1'b1, 1'b0, 10, 0);
    step("R1", 1'b0, 1'b0, 1'b1, 1'b0, 11, 0);
    for (int i = 10; i < 13; i++) step("R2", 1'b0, 1'b1, 1'b1, 1'b0, i, 0);
    // R6 R7: selected, read mode, output enable off
    step("R6", 1'b0, 1'b1, 1'b1, 1'b1, 20, 0);
    step("R7", 1'b0, 1'b1, 1'b1, 1'b1, 21, 0);
    // R4 R8: write with each output-enable level, then read at once
    step("R4", 1'b0, 1'b1, 1'b0, 1'b0, 30, 4'hA);
    step("R8", 1'b0, 1'b1, 1'b1, 1'b0, 30, 0);
    step("R4", 1'b0, 1'b1, 1'b0, 1'b1, 31, 4'h5);
    step("R8", 1'b0, 1'b1, 1'b1, 1'b0, 31, 0);
    step("R4", 1'b0, 1'b1, 1'b0, 1'b0, 255, 4'h0);
    step("R8", 1'b0, 1'b1, 1'b1, 1'b0, 255, 0);
    // R9: alternate writes to neighbours, then read both and the next one
    for (int k = 0; k < 4; k++) begin
      step("R9", 1'b0, 1'b1, 1'b0, 1'b1, 100, k);
      step("R9", 1'b0, 1'b1, 1'b0, 1'b1, 101, 15 - k);
    end
    for (int i = 99; i < 103; i++) step("R9", 1'b0, 1'b1, 1'b1, 1'b0, i, 0);
    // back-to-back writes to one address, last one wins
    step("R3", 1'b0, 1'b1, 1'b0, 1'b0, 0, 4'h3);
    step("R3", 1'b0, 1'b1, 1'b0, 1'b0, 0, 4'hC);
    step("R3", 1'b0, 1'b1, 1'b1, 1'b0, 0, 0);
    @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule